// File: doc/BRIEF.md
# Interrupt Summary and Enable Controller

This block gathers ten interrupt sources into one request line for a host processor. Four of the sources are the summary lines of the GPIO banks. The other six are peripheral request lines. All ten are collected in a pending-status register. The bank bits track their inputs level by level. The peripheral bits latch a request and hold it until software acknowledges it.

A second register holds one enable bit per source and a separate global enable bit. The host request is a registered output. It is high while the global enable is set and at least one pending source is also enabled. The host watches this line for a rising edge.

Software reaches both registers through a simple single-cycle write port and a combinational read port. After reset every register is zero, so the host line stays low until software sets the global enable.

Top module: `irq_summary_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the status register, the enable register and the host request all read 0, whatever the source inputs are.
- R2: Status bits 0 to 3 hold the level that bank inputs 0 to 3 had at the previous clock edge. They are not sticky.
- R3: Peripheral input k (k = 0..5) sets status bit 4+k at the clock edge where the input is sampled high. The bit then stays set after the input falls.
- R4: A write to the status register (address 0) clears each peripheral bit whose write-data bit is 1. Write-data bits that are 0 leave their bits unchanged. Write-data bits 0 to 3 have no effect on the bank bits.
- R5: If a peripheral input is sampled high in the same cycle that a write-1 clear targets its bit, the bit stays set.
- R6: A write to the enable register (address 1) stores data bits 0 to 9 as the per-source enables, with 1 meaning enabled, and stores data bit 15 as the global enable. Reads return those bits in the same places and 0 in bits 10 to 14.
- R7: One clock after the global enable is 1 and some status bit is 1 together with its enable bit, the host request is 1. One clock after no enabled source is pending, it is 0.
- R8: While the global enable is 0, the host request is 0 one cycle later, whatever the status and enable bits are.
- R9: Reads of the status register return 0 in bits 10 to 15. The read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_irq_i | input | 4 | Level summary lines from GPIO banks 0..3 |
| periph_irq_i | input | 6 | Peripheral request lines, sampled each cycle |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| host_irq_o | output | 1 | Registered request line to the host |

## Verification
Two functions can land in one cycle: a peripheral request setting a pending bit, and a software write-1 acknowledge clearing that same bit. Directed cycles drive the input high while the acknowledge write is made. The random phase then crosses clears, new requests and enable writes on the same edges. Each result is compared with a bench model in which a new request takes priority over the clear. The model also predicts the host line one cycle behind the status and enable registers it reads.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned DEF_N_BANK   = 4;
    localparam int unsigned DEF_N_PERIPH = 6;
    localparam int unsigned DEF_REG_W    = 16;
    localparam int unsigned DEF_GIE_BIT  = 15;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     strobe;
        reg_sel_e sel;
    } reg_req_t;

    function automatic reg_req_t decode_req(input logic wr, input logic addr);
        reg_req_t r;
        r.strobe = wr;
        r.sel    = reg_sel_e'(addr);
        return r;
    endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (req_i[k])
                q <= 1'b1;
            else if (ack_i[k])
                q <= 1'b0;
        end
        assign pend_o[k] = q;

        assert_set_R3: assert property (@(posedge clk) disable iff (rst)
            req_i[k] |=> q);
        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (q && !ack_i[k]) |=> q);
        assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
            (ack_i[k] && !req_i[k]) |=> !q);
        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            (ack_i[k] && req_i[k]) |=> q);
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int unsigned N_SRC   = 10,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned GIE_BIT = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [N_SRC-1:0] en_o,
    output logic             gie_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o  <= '0;
            gie_o <= 1'b0;
        end else if (we_i) begin
            en_o  <= wdata_i[N_SRC-1:0];
            gie_o <= wdata_i[GIE_BIT];
        end
    end

    assert_store_R6: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (en_o == $past(wdata_i[N_SRC-1:0])) && (gie_o == $past(wdata_i[GIE_BIT])));
    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(en_o) && $stable(gie_o));
endmodule

// File: rtl/irq_host_out.sv
module irq_host_out #(
    parameter int unsigned N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             gie_i,
    output logic             irq_o
);
    logic any_live;
    assign any_live = |(pend_i & en_i);

    always_ff @(posedge clk) begin
        if (rst)
            irq_o <= 1'b0;
        else
            irq_o <= gie_i & any_live;
    end

    assert_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (gie_i && (|(pend_i & en_i))) |=> irq_o);
    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_i) == '0) |=> !irq_o);
    assert_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !gie_i |=> !irq_o);
endmodule

// File: rtl/irq_summary_ctrl.sv
module irq_summary_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_BANK   = DEF_N_BANK,
    parameter int unsigned N_PERIPH = DEF_N_PERIPH,
    parameter int unsigned REG_W    = DEF_REG_W,
    parameter int unsigned GIE_BIT  = DEF_GIE_BIT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_BANK-1:0]   bank_irq_i,
    input  logic [N_PERIPH-1:0] periph_irq_i,
    input  logic                reg_wr_i,
    input  logic                reg_addr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                host_irq_o
);
    localparam int unsigned N_SRC = N_BANK + N_PERIPH;

    reg_req_t            req;
    logic [N_BANK-1:0]   bank_q;
    logic [N_PERIPH-1:0] periph_pend;
    logic [N_PERIPH-1:0] periph_ack;
    logic [N_SRC-1:0]    status;
    logic [N_SRC-1:0]    src_en;
    logic                gie;

    assign req = decode_req(reg_wr_i, reg_addr_i);

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else
            bank_q <= bank_irq_i;
    end

    assign periph_ack = (req.strobe && req.sel == SEL_STATUS)
                        ? reg_wdata_i[N_SRC-1:N_BANK] : '0;

    irq_src_latch #(.N(N_PERIPH)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .req_i  (periph_irq_i),
        .ack_i  (periph_ack),
        .pend_o (periph_pend)
    );

    assign status = {periph_pend, bank_q};

    irq_enable_reg #(.N_SRC(N_SRC), .REG_W(REG_W), .GIE_BIT(GIE_BIT)) u_enable (
        .clk     (clk),
        .rst     (rst),
        .we_i    (req.strobe && req.sel == SEL_ENABLE),
        .wdata_i (reg_wdata_i),
        .en_o    (src_en),
        .gie_o   (gie)
    );

    irq_host_out #(.N_SRC(N_SRC)) u_out (
        .clk    (clk),
        .rst    (rst),
        .pend_i (status),
        .en_i   (src_en),
        .gie_i  (gie),
        .irq_o  (host_irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (req.sel == SEL_STATUS) begin
            reg_rdata_o[N_SRC-1:0] = status;
        end else begin
            reg_rdata_o[N_SRC-1:0] = src_en;
            reg_rdata_o[GIE_BIT]   = gie;
        end
    end

    assert_bank_follow_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bank_q == $past(bank_irq_i)));
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (status == '0) && (src_en == '0) && !gie && !host_irq_o);
endmodule

// File: tb/irq_summary_ctrl_test.sv
module irq_summary_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bank_irq_i;
    logic [5:0]  periph_irq_i;
    logic        reg_wr_i;
    logic        reg_addr_i;
    logic [15:0] reg_wdata_i;
    logic [15:0] reg_rdata_o;
    logic        host_irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [9:0] m_st;
    logic [9:0] m_en;
    logic       m_gie;
    logic       m_irq;

    always #4 clk = ~clk;

    irq_summary_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .bank_irq_i   (bank_irq_i),
        .periph_irq_i (periph_irq_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .host_irq_o   (host_irq_o)
    );

    function automatic logic [9:0] next_status(logic [9:0] st, logic [3:0] bank,
                                               logic [5:0] per, logic wr, logic addr,
                                               logic [15:0] wd);
        logic [5:0] clr = (wr && !addr) ? wd[9:4] : 6'b0;
        return {(st[9:4] & ~clr) | per, bank};
    endfunction

    function automatic logic next_irq(logic [9:0] st, logic [9:0] en, logic gie);
        return gie & (|(st & en));
    endfunction

    task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        reg_addr_i = 1'b0;
        #1 chk(tag, "status", reg_rdata_o, {6'b0, m_st});
        reg_addr_i = 1'b1;
        #1 chk(tag, "enable", reg_rdata_o, {m_gie, 5'b0, m_en});
        chk(tag, "host_irq", {15'b0, host_irq_o}, {15'b0, m_irq});
    endtask

    task automatic cyc(logic [3:0] bank, logic [5:0] per, logic wr, logic addr,
                       logic [15:0] wd, string tag);
        logic [9:0] nst;
        bank_irq_i   = bank;
        periph_irq_i = per;
        reg_wr_i     = wr;
        reg_addr_i   = addr;
        reg_wdata_i  = wd;
        @(posedge clk);
        nst   = next_status(m_st, bank, per, wr, addr, wd);
        m_irq = next_irq(m_st, m_en, m_gie);
        if (wr && addr) begin
            m_en  = wd[9:0];
            m_gie = wd[15];
        end
        m_st = nst;
        @(negedge clk);
        reg_wr_i = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst          = 1'b1;
        bank_irq_i   = 4'hF;
        periph_irq_i = 6'h3F;
        reg_wr_i     = 1'b1;
        reg_addr_i   = 1'b1;
        reg_wdata_i  = 16'hFFFF;
        m_st = '0; m_en = '0; m_gie = 1'b0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        reg_wr_i = 1'b0;
        check_all("R1");
        rst = 1'b0;

        // R1: first cycle after reset, quiet inputs
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R1");
        // R2: bank bits follow level, not sticky
        cyc(4'hA, 6'h00, 1'b0, 1'b0, 16'h0, "R2");
        cyc(4'h5, 6'h00, 1'b0, 1'b0, 16'h0, "R2");
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R2");
        // R3: single-cycle pulse on peripheral 1 and 5 stays latched
        cyc(4'h0, 6'h22, 1'b0, 1'b0, 16'h0, "R3");
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R3");
        // R4: write 0 has no effect, write 1 clears only its bit, bank bits unaffected
        cyc(4'h3, 6'h00, 1'b1, 1'b0, 16'h0000, "R4");
        cyc(4'h3, 6'h00, 1'b1, 1'b0, 16'h020F, "R4");
        // R5: request and clear collide on bit 5
        cyc(4'h0, 6'h02, 1'b1, 1'b0, 16'h0020, "R5");
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R5");
        // R6: enable register keeps bits 0-9 and 15 only
        cyc(4'h0, 6'h00, 1'b1, 1'b1, 16'h7FFF, "R6");
        // R8: enabled pending source but no global enable
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R8");
        // R7: set global enable, request rises one cycle later
        cyc(4'h0, 6'h00, 1'b1, 1'b1, 16'h8020, "R7");
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R7");
        // R7: clear the pending bit, request drops
        cyc(4'h0, 6'h00, 1'b1, 1'b0, 16'h0020, "R7");
        cyc(4'h0, 6'h00, 1'b0, 1'b0, 16'h0, "R7");
        // R7: bank source enabled alone
        cyc(4'h4, 6'h00, 1'b1, 1'b1, 16'h8004, "R7");
        cyc(4'h4, 6'h00, 1'b0, 1'b0, 16'h0, "R7");
        // R8: drop global enable with source still live
        cyc(4'h4, 6'h00, 1'b1, 1'b1, 16'h0004, "R8");
        cyc(4'h4, 6'h00, 1'b0, 1'b0, 16'h0, "R8");
        // R9: status upper bits always read 0
        cyc(4'hF, 6'h3F, 1'b1, 1'b0, 16'hFC00, "R9");

        for (int i = 0; i < 400; i++) begin
            logic [3:0]  b  = 4'($urandom);
            logic [5:0]  p  = (($urandom % 4) == 0) ? 6'($urandom) : 6'h00;
            logic        w  = (($urandom % 3) == 0);
            logic        a  = 1'($urandom);
            logic [15:0] wd = 16'($urandom);
            cyc(b, p, w, a, wd, "R2 R3 R4 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule